// File: doc/BRIEF.md
# Toggle-Handshake Word RAM Driver with Accumulating Datapath

This block wraps a single-port word memory behind a driver, so that a state-machine datapath never indexes the storage array itself. To make a request, the datapath places a byte address, write data and a write flag on registered signals and then inverts a request flag. The driver keeps an acknowledge flag of its own. On every falling clock edge it compares the two flags. When they differ, it performs exactly one word read or one word write and copies the request flag into the acknowledge flag. Every access to the array sits in that single falling-edge process, so synthesis can map the storage onto a block RAM.

A small example datapath shows how the driver is used. When started, it can first fill a run of consecutive words with a generated sequence, writing one word per cycle. It then reads the same run back and accumulates a 32-bit wrapping sum. Each load needs two cycles: an issue cycle, then a wait cycle in which the read result becomes usable. Stores need no extra cycle. The datapath converts a byte address to a word index by dropping the two low bits. The driver refuses a byte address that is not a multiple of four: it performs no access and raises an error output instead.

Top module: `tgl_ram_accum`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `load_wait` and `err` are 0 and `sum` is 0; request and acknowledge flags are equal, so no access is pending.
- R2: An access requested by a flag inversion at a rising edge is performed at the next falling edge; `err` takes the alignment status of that access from that falling edge on, so it changes in the cycle after the issue.
- R3: At most one access is performed per clock cycle and none is left pending at a rising edge; a load issued in the cycle right after a store to the same word returns the stored value.
- R4: The word index is the byte address with its two low bits removed (byte address divided by four), taken modulo the memory depth; runs that cross the top word wrap to word 0.
- R5: The driver's read data changes only when an aligned load is performed, and `sum` changes only in the cycle where `done` is high.
- R6: Every load occupies exactly two cycles: an issue cycle with `load_wait` low, then one wait cycle with `load_wait` high; `load_wait` is never high in two consecutive cycles.
- R7: Every store occupies exactly one cycle with no wait cycle. A run with fill enabled and count N keeps `busy` high for N + 2N + 1 cycles; without fill, for 2N + 1 cycles.
- R8: If the byte address of an access is not a multiple of four (low two bits nonzero), the driver writes nothing, reads nothing (read data holds) and `err` becomes 1; an aligned access sets `err` back to 0.
- R9: Fill element i (from 0) is `seed + i * FILL_STEP` modulo 2^32 and is written at byte address `base_addr + 4*i`; `sum` is the modulo-2^32 sum of the N words read.
- R10: A start with `count` of 0 performs no access, keeps `busy` high for one cycle, reports `sum` = 0 and leaves `err` unchanged.
- R11: `done` is high for exactly one cycle, the first cycle in which `busy` is low after a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the datapath uses rising edges and the driver falling edges |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when the datapath is idle |
| fill | input | 1 | 1: write the generated sequence before summing; 0: sum only |
| base_addr | input | ADDR_W (10) | Byte address of the first word of the run |
| count | input | CNT_W (9) | Number of words in the run |
| seed | input | DATA_W (32) | First value of the generated sequence |
| busy | output | 1 | High while a run is in progress |
| load_wait | output | 1 | High in the wait cycle that follows each load issue |
| done | output | 1 | One-cycle pulse when a run completes |
| sum | output | DATA_W (32) | Result of the most recent run |
| err | output | 1 | Alignment fault of the most recent access |

## Verification
The assertions rely on the datapath inverting the request flag at most once per rising edge. This lets the falling-edge driver catch up before the next rising edge. They also assume reset is held across at least one falling edge, so that both flags start equal. The stimulus pulses `start` for one cycle only while the block is idle, and holds reset for several full cycles. Misaligned byte addresses are applied on purpose, through `base_addr`, to exercise the fault path. The reference model tracks the last word that was really read, so it can predict the sums those runs produce.

// File: rtl/tgl_ram_pkg.sv
package tgl_ram_pkg;

  // Two low byte-address bits select a byte inside a 32-bit word.
  localparam int LANE_LG = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STORE,
    ST_LOAD,
    ST_LWAIT,
    ST_FINISH
  } dp_state_e;

endpackage

// File: rtl/addr_xlate.sv
// Byte address to word index, plus alignment test.
module addr_xlate #(
  parameter int ADDR_W = 10,
  localparam int IDX_W = ADDR_W - tgl_ram_pkg::LANE_LG
) (
  input  logic [ADDR_W-1:0] byte_addr,
  output logic [IDX_W-1:0]  word_idx,
  output logic              misaligned
);
  localparam int LG = tgl_ram_pkg::LANE_LG;

  always_comb begin
    word_idx   = byte_addr[ADDR_W-1:LG];
    misaligned = |byte_addr[LG-1:0];
  end
endmodule

// File: rtl/tgl_mem_driver.sv
// Falling-edge RAM driver: the only process that touches the word array.
module tgl_mem_driver #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 256,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_tgl,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic              misaligned,
  input  logic [DATA_W-1:0] wdata,
  output logic              ack_tgl,
  output logic [DATA_W-1:0] rdata,
  output logic              fault
);
  logic [DATA_W-1:0] store_q [WORDS];
  logic              ack_q;
  logic [DATA_W-1:0] rdata_q;
  logic              fault_q;

  always_ff @(negedge clk) begin
    if (rst) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
      fault_q <= 1'b0;
    end else if (req_tgl != ack_q) begin
      ack_q   <= req_tgl;
      fault_q <= misaligned;
      if (!misaligned) begin
        if (we) begin
          store_q[idx] <= wdata;
        end else begin
          rdata_q <= store_q[idx];
        end
      end
    end
  end

  assign ack_tgl = ack_q;
  assign rdata   = rdata_q;
  assign fault   = fault_q;
endmodule

// File: rtl/accum_fsm.sv
// Example datapath: optional fill, then load-and-accumulate with a wait per load.
module accum_fsm #(
  parameter int              DATA_W    = 32,
  parameter int              ADDR_W    = 10,
  parameter int              CNT_W     = 9,
  parameter logic [DATA_W-1:0] FILL_STEP = 32'h0001_0003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fill,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] seed,
  input  logic [DATA_W-1:0] rdata,
  output logic              req_tgl,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              load_wait,
  output logic              done,
  output logic [DATA_W-1:0] sum
);
  import tgl_ram_pkg::*;

  localparam int LG = tgl_ram_pkg::LANE_LG;

  dp_state_e         state;
  logic [CNT_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] seed_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] sum_q;
  logic              done_q;
  logic              req_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  logic [ADDR_W-1:0] next_addr;
  logic [DATA_W-1:0] fill_val;
  logic              last;

  always_comb begin
    next_addr = base_q + ADDR_W'({idx, {LG{1'b0}}});
    fill_val  = seed_q + DATA_W'(idx) * FILL_STEP;
    last      = (idx + CNT_W'(1)) == cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      seed_q  <= '0;
      acc_q   <= '0;
      sum_q   <= '0;
      done_q  <= 1'b0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            base_q <= base_addr;
            cnt_q  <= count;
            seed_q <= seed;
            idx    <= '0;
            acc_q  <= '0;
            if (count == '0)  state <= ST_FINISH;
            else if (fill)    state <= ST_STORE;
            else              state <= ST_LOAD;
          end
        end
        ST_STORE: begin
          addr_q  <= next_addr;
          wdata_q <= fill_val;
          we_q    <= 1'b1;
          req_q   <= ~req_q;
          if (last) begin
            idx   <= '0;
            state <= ST_LOAD;
          end else begin
            idx   <= idx + CNT_W'(1);
          end
        end
        ST_LOAD: begin
          addr_q <= next_addr;
          we_q   <= 1'b0;
          req_q  <= ~req_q;
          state  <= ST_LWAIT;
        end
        ST_LWAIT: begin
          acc_q <= acc_q + rdata;
          if (last) begin
            state <= ST_FINISH;
          end else begin
            idx   <= idx + CNT_W'(1);
            state <= ST_LOAD;
          end
        end
        ST_FINISH: begin
          sum_q  <= acc_q;
          done_q <= 1'b1;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_tgl   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;
  assign busy      = (state != ST_IDLE);
  assign load_wait = (state == ST_LWAIT);
  assign done      = done_q;
  assign sum       = sum_q;
endmodule

// File: rtl/tgl_ram_accum.sv
module tgl_ram_accum #(
  parameter int                DATA_W    = 32,
  parameter int                WORDS     = 256,
  parameter logic [DATA_W-1:0] FILL_STEP = 32'h0001_0003,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int ADDR_W = IDX_W + tgl_ram_pkg::LANE_LG,
  localparam int CNT_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fill,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] seed,
  output logic              busy,
  output logic              load_wait,
  output logic              done,
  output logic [DATA_W-1:0] sum,
  output logic              err
);
  logic              req_tgl;
  logic              ack_tgl;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic [IDX_W-1:0]  word_idx;
  logic              misaligned;
  logic [DATA_W-1:0] rd_data;
  logic              fault;

  accum_fsm #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FILL_STEP(FILL_STEP)
  ) u_dp (
    .clk(clk), .rst(rst), .start(start), .fill(fill),
    .base_addr(base_addr), .count(count), .seed(seed), .rdata(rd_data),
    .req_tgl(req_tgl), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .load_wait(load_wait),
    .done(done), .sum(sum)
  );

  addr_xlate #(.ADDR_W(ADDR_W)) u_xlate (
    .byte_addr(mem_addr), .word_idx(word_idx), .misaligned(misaligned)
  );

  tgl_mem_driver #(.DATA_W(DATA_W), .WORDS(WORDS)) u_drv (
    .clk(clk), .rst(rst), .req_tgl(req_tgl), .we(mem_we), .idx(word_idx),
    .misaligned(misaligned), .wdata(mem_wdata), .ack_tgl(ack_tgl),
    .rdata(rd_data), .fault(fault)
  );

  assign err = fault;
endmodule

// File: rtl/tgl_ram_accum_chk.sv
module tgl_ram_accum_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_tgl,
  input logic              ack_tgl,
  input logic              mem_we,
  input logic              misaligned,
  input logic [DATA_W-1:0] rd_data,
  input logic              fault,
  input logic              busy,
  input logic              load_wait,
  input logic              done,
  input logic [DATA_W-1:0] sum
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !done && !load_wait && req_tgl == ack_tgl));

  p_serviced_next_fall_r2: assert property (@(negedge clk) disable iff (rst)
    (req_tgl != ack_tgl) |=> (ack_tgl == $past(req_tgl)));

  p_no_backlog_r3: assert property (@(posedge clk) disable iff (rst)
    req_tgl == ack_tgl);

  p_rdata_hold_r5: assert property (@(negedge clk) disable iff (rst)
    !(req_tgl != ack_tgl && !mem_we && !misaligned) |=> $stable(rd_data));

  p_sum_moves_on_done_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sum) |-> done);

  p_single_wait_r6: assert property (@(posedge clk) disable iff (rst)
    load_wait |=> !load_wait);

  p_fault_on_odd_r8: assert property (@(negedge clk) disable iff (rst)
    (req_tgl != ack_tgl && misaligned) |=> fault);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind tgl_ram_accum tgl_ram_accum_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_tgl(req_tgl), .ack_tgl(ack_tgl),
  .mem_we(mem_we), .misaligned(misaligned), .rd_data(rd_data),
  .fault(fault), .busy(busy), .load_wait(load_wait), .done(done), .sum(sum)
);

// File: tb/tgl_ram_accum_test.sv
module tgl_ram_accum_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int WORDS  = 256;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int ADDR_W = IDX_W + 2;
  localparam int CNT_W  = IDX_W + 1;
  localparam logic [31:0] STEP = 32'h0001_0003;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              fill = 1'b0;
  logic [ADDR_W-1:0] base_addr = '0;
  logic [CNT_W-1:0]  count = '0;
  logic [31:0]       seed = '0;
  logic              busy, load_wait, done, err;
  logic [31:0]       sum;

  int vectors = 0;
  int miscompares = 0;

  logic [31:0] mdl_mem [WORDS];
  logic [31:0] mdl_rd  = '0;
  logic [31:0] mdl_sum = '0;
  logic        mdl_err = 1'b0;

  tgl_ram_accum #(.DATA_W(DATA_W), .WORDS(WORDS), .FILL_STEP(STEP)) uut (
    .clk(clk), .rst(rst), .start(start), .fill(fill), .base_addr(base_addr),
    .count(count), .seed(seed), .busy(busy), .load_wait(load_wait),
    .done(done), .sum(sum), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One run: model first, then cycle-by-cycle comparison.
  task automatic run(logic do_fill, logic [ADDR_W-1:0] b, int n, logic [31:0] s);
    int          f = do_fill ? n : 0;
    int          total = f + 2 * n + 1;
    logic        mis = (b[1:0] != 2'b00);
    logic        prev_err = mdl_err;
    logic [31:0] new_sum = '0;
    if (do_fill && !mis)
      for (int i = 0; i < n; i++)
        mdl_mem[(int'(b >> 2) + i) % WORDS] = s + i * STEP;
    for (int i = 0; i < n; i++) begin
      if (!mis) mdl_rd = mdl_mem[(int'(b >> 2) + i) % WORDS];
      new_sum = new_sum + mdl_rd;
    end
    if (n > 0) mdl_err = mis;

    @(posedge clk); #1;
    start = 1'b1; fill = do_fill; base_addr = b; count = CNT_W'(n); seed = s;
    @(posedge clk); #1;
    start = 1'b0;
    for (int j = 0; j <= total; j++) begin
      @(negedge clk); #(CLK_PERIOD/4);
      if (j < f) check("R7", "busy in store phase", busy, 1);
      else       check("R6", "busy", busy, (j < total) ? 1 : 0);
      check("R6", "load_wait", load_wait,
            (j >= f && j < f + 2 * n && ((j - f) % 2) == 1) ? 1 : 0);
      check("R11", "done", done, (j == total) ? 1 : 0);
      if (j < total) check("R5", "sum held", sum, mdl_sum);
      else           check("R9", "sum", sum, new_sum);
      check("R2", "err", err, (j >= 1 && n > 0) ? mis : prev_err);
      @(posedge clk); #1;
    end
    mdl_sum = new_sum;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk); #(CLK_PERIOD/4);
    check("R1", "busy after reset", busy, 0);
    check("R1", "done after reset", done, 0);
    check("R1", "load_wait after reset", load_wait, 0);
    check("R1", "err after reset", err, 0);
    check("R1", "sum after reset", sum, 0);
    @(posedge clk); #1;

    run(1'b1, 10'h000, 8, 32'd5);
    run(1'b0, 10'h000, 8, 32'd0);
    check("R5", "sum-only rerun", sum, mdl_sum);

    run(1'b1, 10'h010, 4, 32'd1000);
    run(1'b0, 10'h000, 8, 32'd0);
    check("R4", "overlap by byte offset", sum, mdl_sum);

    run(1'b1, 10'h002, 3, 32'h0000_FFFF);
    check("R8", "err after misaligned run", err, 1);
    run(1'b0, 10'h000, 8, 32'd0);
    check("R8", "word 0 untouched by misaligned store", sum, mdl_sum);
    check("R8", "err after aligned run", err, 0);

    run(1'b0, 10'h000, 0, 32'd7);
    check("R10", "empty run sum", sum, 0);

    run(1'b1, 10'h028, 1, 32'h0000_ABCD);
    check("R3", "load right after store", sum, 32'h0000_ABCD);

    run(1'b1, 10'h3F8, 4, 32'hFFFF_FFF0);
    check("R4", "wrap past top word", sum, mdl_sum);
    run(1'b0, 10'h000, 8, 32'd0);
    check("R9", "wrapping sum after overflow fill", sum, mdl_sum);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    miscompares++;
    $display("FAIL R6 watchdog: actual still running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule